// File: doc/BRIEF.md
# External Interrupt Sense and Pending Unit

This unit watches eight external interrupt pins, numbered 0 to 7, all of them active low. It resynchronises each pin to the core clock. Software chooses, pin by pin, whether a pin is detected as a low level or as a high-to-low transition. A detected transition is held in a sticky flag until software clears it. A level source is simply reported for as long as its pin stays low.

Every pending source is gated by an enable bit. The enabled sources drive one combined request line to the processor. A fixed priority encoder turns the winning source into a 7-bit code, and the code 0 means that nothing is pending.

Software reaches the unit through four 32-bit word registers on a simple write-strobe bus. The read path is combinational:

- word 0: sense selection and the machine-check routing flag
- word 1: enable bits
- word 2: pending flags, cleared by writing 1
- word 3: the winning code, read-only

Pin 0 can optionally be steered to a separate machine-check output.

Top module: `ext_irq_unit`

## Requirements
- R1: After reset, the sense word reads 0, the enable word reads 0, the pending word reads 0 while all pins are high, the code word reads 0, and both cpu_irq and mchk_irq are low.
- R2: In the sense word (word 0), pin N's sense bit sits at LSB-numbered bit 15-N. A 1 selects falling-edge detection and a 0 selects low-level detection. Bit 0 is the machine-check routing flag. The word reads back exactly what was written in these nine bits.
- R3: A pin in level sense shows pending at LSB-numbered bit 31-N of word 2 while its synchronised input is low, and stops once the input is high. Writing 1 to that bit leaves it set while the pin stays low.
- R4: A pin in edge sense sets its pending flag on a high-to-low transition. The flag stays set after the pin returns high. A low-to-high transition never sets it.
- R5: Writing 1 at bit 31-N of word 2 clears pin N's edge flag. Writing 0 there leaves the flag unchanged.
- R6: The enable word (word 1) uses bit 31-N for pin N, with 1 meaning enabled. A pending but disabled source shows in word 2 but raises neither cpu_irq nor a nonzero code.
- R7: The code word (word 3, low 7 bits) reports 48 for pin 0, reports 16+N (17 to 23) for pins 1 to 7, and reports 0 when no enabled source is pending. cpu_irq is high exactly when that code is nonzero.
- R8: When several enabled sources are pending, the lowest-numbered pin wins the code.
- R9: If a falling edge and a write-1-to-clear reach the same flag on the same clock edge, the flag stays set.
- R10: With the routing flag set, pin 0 drives mchk_irq (when it is pending and enabled) and is excluded from cpu_irq and from the code.
- R11: Writes to word 3 change no register and do not alter the reported code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_pin_n | input | 8 | External interrupt pins, active low, asynchronous |
| bus_we | input | 1 | Register write strobe, sampled on the rising clock edge |
| bus_addr | input | 2 | Word index: 0 sense, 1 enable, 2 pending, 3 code |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| cpu_irq | output | 1 | Combined interrupt request to the processor |
| mchk_irq | output | 1 | Machine-check request from pin 0 when routed |

## Verification
The bench times a clearing write to land on the same clock edge on which a new falling edge is registered. A design that gives the clear priority would drop that event, and the flag would read 0 (R9).

It writes a clearing 1 to a level-sensed bit while the pin is held low. A design that latches level sources would then show the bit as cleared.

It lets a pin rise after its flag is cleared. A design that detects any change on the pin would set the flag again.

It checks the opposite bit orderings of the sense word and the pending and enable words. An ordering mix-up shows up as the wrong bit read back or the wrong pin acting.

It drives several pins low together and releases them one at a time, so that a reversed priority order or a wrong code map shows in the code word. It also sets the routing flag, so that a design which leaks pin 0 into cpu_irq is exposed.

// File: rtl/ext_irq_unit.sv
module ext_irq_unit #(
  parameter int NPIN = 8,
  parameter int DW   = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NPIN-1:0] irq_pin_n,
  input  logic            bus_we,
  input  logic [1:0]      bus_addr,
  input  logic [DW-1:0]   bus_wdata,
  output logic [DW-1:0]   bus_rdata,
  output logic            cpu_irq,
  output logic            mchk_irq
);
  localparam int SENSE_TOP = 15;
  localparam int FLAG_TOP  = DW - 1;
  localparam int CODE_W    = 7;

  localparam logic [1:0] A_SENSE = 2'd0;
  localparam logic [1:0] A_EN    = 2'd1;
  localparam logic [1:0] A_PEND  = 2'd2;
  localparam logic [1:0] A_CODE  = 2'd3;

  logic [NPIN-1:0] meta_q, smp_q, old_q;
  logic [NPIN-1:0] sense_q, en_q, edge_q;
  logic            route_q;
  logic [NPIN-1:0] evt, clr, keep, edge_nxt, pend, cpu_act;
  logic [CODE_W-1:0] vec_code;
  logic [DW-1:0] sense_rd, en_rd, pend_rd;

  wire wr_sense = bus_we && bus_addr == A_SENSE;
  wire wr_en    = bus_we && bus_addr == A_EN;
  wire wr_pend  = bus_we && bus_addr == A_PEND;

  function automatic logic [CODE_W-1:0] src_code(input int i);
    return (i == 0) ? CODE_W'(48) : CODE_W'(16 + i);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '1;
      smp_q  <= '1;
      old_q  <= '1;
    end else begin
      meta_q <= irq_pin_n;
      smp_q  <= meta_q;
      old_q  <= smp_q;
    end
  end

  assign evt  = sense_q & old_q & ~smp_q;
  assign pend = (sense_q & edge_q) | (~sense_q & ~smp_q);

  always_comb begin
    for (int i = 0; i < NPIN; i++) begin
      clr[i]  = wr_pend & bus_wdata[FLAG_TOP-i];
      keep[i] = wr_sense ? bus_wdata[SENSE_TOP-i] : 1'b1;
    end
    edge_nxt = ((edge_q & ~clr) | evt) & keep;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sense_q <= '0;
      route_q <= 1'b0;
      en_q    <= '0;
      edge_q  <= '0;
    end else begin
      if (wr_sense) begin
        for (int i = 0; i < NPIN; i++) sense_q[i] <= bus_wdata[SENSE_TOP-i];
        route_q <= bus_wdata[0];
      end
      if (wr_en) begin
        for (int i = 0; i < NPIN; i++) en_q[i] <= bus_wdata[FLAG_TOP-i];
      end
      edge_q <= edge_nxt;
    end
  end

  assign cpu_act  = pend & en_q & ~{{(NPIN-1){1'b0}}, route_q};
  assign mchk_irq = route_q & pend[0] & en_q[0];
  assign cpu_irq  = |cpu_act;

  always_comb begin
    vec_code = '0;
    for (int i = NPIN - 1; i >= 0; i--)
      if (cpu_act[i]) vec_code = src_code(i);
  end

  always_comb begin
    sense_rd = '0;
    en_rd    = '0;
    pend_rd  = '0;
    sense_rd[0] = route_q;
    for (int i = 0; i < NPIN; i++) begin
      sense_rd[SENSE_TOP-i] = sense_q[i];
      en_rd[FLAG_TOP-i]     = en_q[i];
      pend_rd[FLAG_TOP-i]   = pend[i];
    end
  end

  always_comb begin
    case (bus_addr)
      A_SENSE: bus_rdata = sense_rd;
      A_EN:    bus_rdata = en_rd;
      A_PEND:  bus_rdata = pend_rd;
      A_CODE:  bus_rdata = {{(DW-CODE_W){1'b0}}, vec_code};
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/ext_irq_unit_chk.sv
module ext_irq_unit_chk #(
  parameter int NPIN = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            bus_we,
  input logic [1:0]      bus_addr,
  input logic            cpu_irq,
  input logic            mchk_irq,
  input logic [6:0]      vec_code,
  input logic [NPIN-1:0] evt,
  input logic [NPIN-1:0] edge_q
);
  AST_IRQ_MATCHES_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_irq == (vec_code != 7'd0)); // R7

  AST_CODE_IN_MAP: assert property (@(posedge clk) disable iff (!rst_n)
    vec_code != 7'd0 |-> (vec_code == 7'd48 || (vec_code >= 7'd17 && vec_code <= 7'd23))); // R7

  AST_MCHK_NOT_IN_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    mchk_irq |-> vec_code != 7'd48); // R10

  AST_EDGE_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_we && (bus_addr == 2'd0 || bus_addr == 2'd2)) |=> (($past(edge_q) & ~edge_q) == '0)); // R5

  AST_EVENT_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (!(bus_we && bus_addr == 2'd0) && evt != '0) |=> (($past(evt) & ~edge_q) == '0)); // R9
endmodule

bind ext_irq_unit ext_irq_unit_chk #(.NPIN(NPIN)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
  .cpu_irq(cpu_irq), .mchk_irq(mchk_irq), .vec_code(vec_code),
  .evt(evt), .edge_q(edge_q)
);

// File: tb/ext_irq_unit_tb.sv
module ext_irq_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  irq_pin_n = 8'hFF;
  logic        bus_we = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        cpu_irq, mchk_irq;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  ext_irq_unit dut_i (
    .clk(clk), .rst_n(rst_n), .irq_pin_n(irq_pin_n), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cpu_irq(cpu_irq), .mchk_irq(mchk_irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(0, v); chk("R1 sense", v, 0);
    rd(1, v); chk("R1 enable", v, 0);
    rd(2, v); chk("R1 pending", v, 0);
    rd(3, v); chk("R1 code", v, 0);
    chk("R1 cpu_irq", {31'b0, cpu_irq}, 0);
    chk("R1 mchk_irq", {31'b0, mchk_irq}, 0);
  endtask

  task automatic t_sense_word();
    logic [31:0] v;
    wr(0, 32'h0000_8101);
    rd(0, v); chk("R2 readback", v, 32'h0000_8101);
    wr(0, 32'h0);
    rd(0, v); chk("R2 cleared", v, 0);
  endtask

  task automatic t_level();
    logic [31:0] v;
    wr(1, 32'hFF00_0000);
    irq_pin_n[3] = 1'b0; settle();
    rd(2, v); chk("R3 level pending", v, 32'h1000_0000);
    rd(3, v); chk("R7 code pin3", v, 19);
    chk("R7 irq", {31'b0, cpu_irq}, 1);
    wr(2, 32'h1000_0000);
    rd(2, v); chk("R3 clear ignored", v, 32'h1000_0000);
    irq_pin_n[3] = 1'b1; settle();
    rd(2, v); chk("R3 released", v, 0);
    chk("R3 irq low", {31'b0, cpu_irq}, 0);
  endtask

  task automatic t_edge();
    logic [31:0] v;
    wr(0, 32'h0000_2000);
    irq_pin_n[2] = 1'b0; settle();
    rd(2, v); chk("R4 edge set", v, 32'h2000_0000);
    rd(3, v); chk("R7 code pin2", v, 18);
    irq_pin_n[2] = 1'b1; settle();
    rd(2, v); chk("R4 sticky", v, 32'h2000_0000);
    wr(2, 32'h0);
    rd(2, v); chk("R5 zero write", v, 32'h2000_0000);
    wr(2, 32'h2000_0000);
    rd(2, v); chk("R5 cleared", v, 0);
    irq_pin_n[2] = 1'b0; settle();
    wr(2, 32'h2000_0000);
    rd(2, v); chk("R5 cleared while low", v, 0);
    irq_pin_n[2] = 1'b1; settle();
    rd(2, v); chk("R4 rising ignored", v, 0);
    wr(0, 32'h0);
  endtask

  task automatic t_enable();
    logic [31:0] v;
    wr(1, 32'h0);
    irq_pin_n[5] = 1'b0; settle();
    rd(2, v); chk("R6 visible", v, 32'h0400_0000);
    rd(3, v); chk("R6 masked code", v, 0);
    chk("R6 masked irq", {31'b0, cpu_irq}, 0);
    wr(1, 32'h0400_0000);
    rd(3, v); chk("R6 enabled code", v, 21);
    chk("R6 enabled irq", {31'b0, cpu_irq}, 1);
    irq_pin_n[5] = 1'b1; settle();
  endtask

  task automatic t_priority();
    logic [31:0] v;
    wr(1, 32'hFF00_0000);
    irq_pin_n = 8'b0110_1110; settle();
    rd(3, v); chk("R8 pin0 wins", v, 48);
    irq_pin_n[0] = 1'b1; settle();
    rd(3, v); chk("R8 pin4 next", v, 20);
    irq_pin_n[4] = 1'b1; settle();
    rd(3, v); chk("R8 pin7 last", v, 23);
    irq_pin_n[1] = 1'b0; settle();
    rd(3, v); chk("R7 pin1 code", v, 17);
    irq_pin_n = 8'hFF; settle();
    rd(3, v); chk("R7 none", v, 0);
  endtask

  task automatic t_race();
    logic [31:0] v;
    wr(0, 32'h0000_0200);
    wr(1, 32'hFF00_0000);
    irq_pin_n[6] = 1'b0; settle();
    irq_pin_n[6] = 1'b1; settle();
    rd(2, v); chk("R9 pre-set", v, 32'h0200_0000);
    @(negedge clk); irq_pin_n[6] = 1'b0;
    @(negedge clk);
    @(negedge clk); bus_we = 1'b1; bus_addr = 2'd2; bus_wdata = 32'h0200_0000;
    @(negedge clk); bus_we = 1'b0; bus_wdata = '0;
    rd(2, v); chk("R9 event wins", v, 32'h0200_0000);
    wr(2, 32'h0200_0000);
    rd(2, v); chk("R9 later clear", v, 0);
    irq_pin_n[6] = 1'b1; settle();
    wr(0, 32'h0);
  endtask

  task automatic t_mchk();
    logic [31:0] v;
    wr(0, 32'h0000_0001);
    irq_pin_n[0] = 1'b0; settle();
    chk("R10 mchk", {31'b0, mchk_irq}, 1);
    chk("R10 no cpu", {31'b0, cpu_irq}, 0);
    rd(3, v); chk("R10 code 0", v, 0);
    irq_pin_n[1] = 1'b0; settle();
    rd(3, v); chk("R10 pin1 code", v, 17);
    chk("R10 mchk held", {31'b0, mchk_irq}, 1);
    irq_pin_n = 8'hFF; wr(0, 32'h0); settle();
    chk("R10 mchk off", {31'b0, mchk_irq}, 0);
  endtask

  task automatic t_code_ro();
    logic [31:0] v;
    irq_pin_n[3] = 1'b0; settle();
    wr(3, 32'hFFFF_FFFF);
    rd(3, v); chk("R11 code kept", v, 19);
    rd(1, v); chk("R11 enable kept", v, 32'hFF00_0000);
    rd(0, v); chk("R11 sense kept", v, 0);
    irq_pin_n[3] = 1'b1; settle();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_sense_word();
    t_level();
    t_edge();
    t_enable();
    t_priority();
    t_race();
    t_mchk();
    t_code_ro();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #1_000_000;
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule